// File: doc/BRIEF.md
# Nonvolatile Array Mode and Protection Controller

This block sits behind a serial register interface and in front of a byte-addressed nonvolatile array. The array is modelled in on-chip registers. A mode register selects read, program or erase, and carries a sticky write-protect bit and a clock-extension enable. Software writes the array address at any time. Array requests arrive as single-cycle pulses. Each request is checked against the mode register, the protection state, the locked upper pages and the erased state of the target byte. It is answered one cycle later with an accept or a refuse.

Accepted programs write a single byte. Accepted erases restore a whole page to FFh. Either one runs for a parameterised number of cycles with `busy` raised. If clock extension is off, a request that arrives during that time is refused. If clock extension is on, the request is parked and `hold` is raised, so the bus engine can stretch the clock. The parked request is judged when the cycle ends.

The array geometry is set by parameters. The defaults are 16 pages of 8 bytes with the top 4 pages locked, scaled down for simulation. The same logic covers 128 pages of 64 bytes.

Top module: `eeprom_guard_ctrl`

## Requirements
- R1: The mode register stores bit 0 (read), bit 1 (program), bit 2 (erase), bit 3 (write protect) and bit 7 (clock extension) from `mode_wdata` on `mode_we`. Bits 4 to 6 always read 0 on `mode_q`.
- R2: Once bit 3 has been set, later mode writes cannot clear it. Only `rst_n` clears it.
- R3: A request is refused unless exactly one of mode bits 0 to 2 is set and that bit matches `req_op`. The op codes are 0 for read, 1 for program and 2 for erase, and code 3 is always refused.
- R4: While write protect is set, program and erase are refused and reads are still accepted.
- R5: A program or erase whose address lies in the top LOCK_PAGES pages is refused and changes no byte.
- R6: A program is accepted only if the target byte holds FFh. A refused program leaves the byte unchanged.
- R7: An accepted erase sets every byte of the addressed page to FFh and leaves all other pages untouched.
- R8: After an accepted program, `busy` is high for exactly PROG_CYCLES cycles. After an accepted erase, it is high for exactly ERASE_CYCLES cycles. It rises together with the accepting response.
- R9: With clock extension off, a request made while `busy` is high is refused and has no effect on the array.
- R10: With clock extension on, a request made while `busy` is high gives no immediate response and raises `hold`. It is judged and answered in the cycle after `busy` falls. Requests presented while `hold` is high are dropped without a response.
- R11: Writing the array address via `addr_we` always succeeds, whatever the mode register holds. A later read uses that address.
- R12: Each taken request gives exactly one `resp_valid` pulse, one cycle after it is judged. `resp_ack` is 1 on accept, and `resp_rdata` carries the byte for an accepted read.
- R13: After reset, the mode register is 00h, every array byte is FFh, and `busy`, `hold` and `resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_q | output | 8 | Mode register readback |
| addr_we | input | 1 | Array address write strobe |
| addr_wdata | input | AW | Array address |
| req_valid | input | 1 | Array request pulse |
| req_op | input | 2 | 0 read, 1 program, 2 erase |
| req_wdata | input | 8 | Program data |
| resp_valid | output | 1 | Response pulse |
| resp_ack | output | 1 | 1 = accepted, 0 = refused |
| resp_rdata | output | 8 | Read data for an accepted read |
| busy | output | 1 | Program or erase cycle running |
| hold | output | 1 | Request parked, bus should be stretched |

## Verification
The checker asserts on every cycle the relations that can be seen at the ports:
- write protect never falls outside reset;
- every accept follows a cycle in which exactly one mode bit was set;
- an accept under write protect was a read;
- `busy` only rises together with an accepting response;
- no response appears while a request is parked.

Some behaviours depend on the array contents and on cycle counts, and only the bench scenarios can show them:
- the erased-byte rule;
- whole-page erase leaving neighbour pages intact;
- locked-page refusal;
- the exact length of the busy window;
- a parked request being accepted after the cycle ends.

// File: rtl/eeg_pkg.sv
package eeg_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_PROG  = 2'd1,
    ENG_ERASE = 2'd2
  } eng_e;

  localparam int unsigned MB_READ  = 0;
  localparam int unsigned MB_PROG  = 1;
  localparam int unsigned MB_ERASE = 2;
  localparam int unsigned MB_WP    = 3;
  localparam int unsigned MB_EXT   = 7;
  localparam logic [7:0]  ERASED   = 8'hFF;
endpackage

// File: rtl/eeg_mode_reg.sv
module eeg_mode_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] mode_q
);
  import eeg_pkg::*;

  logic [7:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (we) begin
      mode_d         = 8'h00;
      mode_d[MB_READ]  = wdata[MB_READ];
      mode_d[MB_PROG]  = wdata[MB_PROG];
      mode_d[MB_ERASE] = wdata[MB_ERASE];
      mode_d[MB_EXT]   = wdata[MB_EXT];
      // protect bit only accumulates
      mode_d[MB_WP]    = mode_q[MB_WP] | wdata[MB_WP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 8'h00;
    else if (we) mode_q <= mode_d;
  end
endmodule

// File: rtl/eeg_access_check.sv
module eeg_access_check #(
  parameter int unsigned AW         = 7,
  parameter int unsigned PW         = 3,
  parameter int unsigned NPAGES     = 16,
  parameter int unsigned LOCK_PAGES = 4
) (
  input  logic [7:0]    mode,
  input  eeg_pkg::op_e  op,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    cur_byte,
  output logic          ok
);
  import eeg_pkg::*;

  localparam int unsigned PGW       = AW - PW;
  localparam int unsigned FIRST_LCK = NPAGES - LOCK_PAGES;

  logic single, wp, locked;
  logic [PGW-1:0] page;

  always_comb begin
    page   = addr[AW-1:PW];
    single = $onehot(mode[2:0]);
    wp     = mode[MB_WP];
    locked = (32'(page) >= FIRST_LCK);
    unique case (op)
      OP_READ:  ok = single && mode[MB_READ];
      OP_PROG:  ok = single && mode[MB_PROG] && !wp && !locked && (cur_byte == ERASED);
      OP_ERASE: ok = single && mode[MB_ERASE] && !wp && !locked;
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/eeg_array.sv
module eeg_array #(
  parameter int unsigned AW           = 7,
  parameter int unsigned PW           = 3,
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  eeg_pkg::op_e  start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [7:0]    start_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte,
  output logic          busy
);
  import eeg_pkg::*;

  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYCLES - 1);

  eng_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic [7:0]    dat_q, dat_d;
  logic          done, done_prog, done_erase;
  logic [7:0]    mem [DEPTH];

  assign busy    = (st_q != ENG_IDLE);
  assign rd_byte = mem[rd_addr];

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    tgt_d = tgt_q;
    dat_d = dat_q;
    done  = 1'b0;
    if (st_q == ENG_IDLE) begin
      if (start) begin
        st_d  = (start_op == OP_ERASE) ? ENG_ERASE : ENG_PROG;
        cnt_d = '0;
        tgt_d = start_addr;
        dat_d = start_data;
      end
    end else begin
      done = (cnt_q == ((st_q == ENG_PROG) ? PROG_LAST : ERASE_LAST));
      if (done) st_d = ENG_IDLE;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  assign done_prog  = done && (st_q == ENG_PROG);
  assign done_erase = done && (st_q == ENG_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      cnt_q <= '0;
      tgt_q <= '0;
      dat_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tgt_q <= tgt_d;
      dat_q <= dat_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    localparam logic [AW-1:0] CADDR = AW'(gi);
    logic       cell_we;
    logic [7:0] cell_d;
    always_comb begin
      cell_we = 1'b0;
      cell_d  = ERASED;
      if (done_erase && (CADDR[AW-1:PW] == tgt_q[AW-1:PW])) begin
        cell_we = 1'b1;
      end else if (done_prog && (CADDR == tgt_q)) begin
        cell_we = 1'b1;
        cell_d  = dat_q;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[gi] <= ERASED;
      else if (cell_we) mem[gi] <= cell_d;
    end
  end
endmodule

// File: rtl/eeprom_guard_ctrl.sv
module eeprom_guard_ctrl #(
  parameter int unsigned NPAGES       = 16,
  parameter int unsigned PAGE_BYTES   = 8,
  parameter int unsigned LOCK_PAGES   = 4,
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 30,
  localparam int unsigned AW          = $clog2(NPAGES * PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [7:0]    mode_wdata,
  output logic [7:0]    mode_q,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_wdata,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [7:0]    req_wdata,
  output logic          resp_valid,
  output logic          resp_ack,
  output logic [7:0]    resp_rdata,
  output logic          busy,
  output logic          hold
);
  import eeg_pkg::*;

  localparam int unsigned PW = $clog2(PAGE_BYTES);

  logic [AW-1:0] addr_q;
  logic          pend_q, pend_d;
  op_e           pend_op_q;
  logic [AW-1:0] pend_addr_q;
  logic [7:0]    pend_data_q;
  logic          rv_d, ack_d;
  logic [7:0]    rdata_d;

  logic          take_new, park, refuse_busy, eval, ok, start;
  op_e           sel_op;
  logic [AW-1:0] sel_addr;
  logic [7:0]    sel_data, cur_byte;

  eeg_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .wdata(mode_wdata), .mode_q(mode_q)
  );

  eeg_access_check #(.AW(AW), .PW(PW), .NPAGES(NPAGES), .LOCK_PAGES(LOCK_PAGES)) u_chk (
    .mode(mode_q), .op(sel_op), .addr(sel_addr), .cur_byte(cur_byte), .ok(ok)
  );

  eeg_array #(.AW(AW), .PW(PW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_arr (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(sel_op),
    .start_addr(sel_addr), .start_data(sel_data),
    .rd_addr(sel_addr), .rd_byte(cur_byte), .busy(busy)
  );

  always_comb begin
    take_new    = req_valid && !pend_q;
    park        = take_new && busy && mode_q[MB_EXT];
    refuse_busy = take_new && busy && !mode_q[MB_EXT];
    eval        = !busy && (pend_q || take_new);
    sel_op      = pend_q ? pend_op_q   : op_e'(req_op);
    sel_addr    = pend_q ? pend_addr_q : addr_q;
    sel_data    = pend_q ? pend_data_q : req_wdata;
    start       = eval && ok && (sel_op != OP_READ);
    rv_d        = eval || refuse_busy;
    ack_d       = eval && ok;
    rdata_d     = (eval && ok && (sel_op == OP_READ)) ? cur_byte : 8'h00;
    pend_d      = pend_q;
    if (park) pend_d = 1'b1;
    else if (eval && pend_q) pend_d = 1'b0;
  end

  assign hold = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (addr_we) addr_q <= addr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_op_q   <= OP_READ;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (park) begin
        pend_op_q   <= op_e'(req_op);
        pend_addr_q <= addr_q;
        pend_data_q <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      resp_rdata <= 8'h00;
    end else begin
      resp_valid <= rv_d;
      resp_ack   <= ack_d;
      resp_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/eeg_guard_chk.sv
module eeg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mode_q,
  input logic       busy,
  input logic       hold,
  input logic       resp_valid,
  input logic       resp_ack
);
  p_wp_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q[3]) |-> mode_q[3]);

  p_single_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ack) |-> $onehot($past(mode_q[2:0])));

  p_wp_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ack && $past(mode_q[3])) |-> $past(mode_q[0]));

  p_busy_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (resp_valid && resp_ack));

  p_silent_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !resp_valid);

  p_hold_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !busy) |=> !hold);

  p_ack_qualified_r12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ack |-> resp_valid);
endmodule

bind eeprom_guard_ctrl eeg_guard_chk u_guard_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .busy(busy), .hold(hold),
  .resp_valid(resp_valid), .resp_ack(resp_ack)
);

// File: tb/tb_eeprom_guard_ctrl.sv
module tb_eeprom_guard_ctrl;
  localparam int unsigned NP = 16, PB = 8, LP = 4, PC = 20, EC = 30;
  localparam int unsigned AW = $clog2(NP * PB);

  logic clk, rst_n;
  logic mode_we, addr_we, req_valid;
  logic [7:0] mode_wdata, req_wdata, mode_q, resp_rdata;
  logic [AW-1:0] addr_wdata;
  logic [1:0] req_op;
  logic resp_valid, resp_ack, busy, hold;

  int checks = 0, errors = 0;
  bit done = 0;

  eeprom_guard_ctrl #(.NPAGES(NP), .PAGE_BYTES(PB), .LOCK_PAGES(LP),
                      .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_q(mode_q), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .req_valid(req_valid), .req_op(req_op), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_rdata(resp_rdata),
    .busy(busy), .hold(hold)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [7:0] mode;
    logic [7:0] addr;
    logic [1:0] op;
    logic [7:0] wdata;
    logic       ack;
    logic [7:0] rdata;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'd5,   2'd0, 8'h00, 1'b1, 8'hFF},  // R3 read erased
    '{8'h02, 8'd5,   2'd1, 8'h3C, 1'b1, 8'h00},  // R6 program erased byte
    '{8'h01, 8'd5,   2'd0, 8'h00, 1'b1, 8'h3C},  // R12 read back
    '{8'h02, 8'd5,   2'd1, 8'h00, 1'b0, 8'h00},  // R6 not erased
    '{8'h01, 8'd5,   2'd0, 8'h00, 1'b1, 8'h3C},  // R6 unchanged
    '{8'h00, 8'd5,   2'd0, 8'h00, 1'b0, 8'h00},  // R3 no mode bit
    '{8'h03, 8'd5,   2'd0, 8'h00, 1'b0, 8'h00},  // R3 two mode bits
    '{8'h01, 8'd6,   2'd1, 8'h11, 1'b0, 8'h00},  // R3 op mismatch
    '{8'h02, 8'd100, 2'd1, 8'h22, 1'b0, 8'h00},  // R5 locked program
    '{8'h04, 8'd100, 2'd2, 8'h00, 1'b0, 8'h00},  // R5 locked erase
    '{8'h01, 8'd100, 2'd0, 8'h00, 1'b1, 8'hFF},  // R5 locked byte intact
    '{8'h02, 8'd6,   2'd1, 8'h5A, 1'b1, 8'h00},  // R6 second byte
    '{8'h02, 8'd8,   2'd1, 8'hA5, 1'b1, 8'h00},  // R6 byte in page 1
    '{8'h04, 8'd7,   2'd2, 8'h00, 1'b1, 8'h00},  // R7 erase page 0
    '{8'h01, 8'd5,   2'd0, 8'h00, 1'b1, 8'hFF},  // R7 erased
    '{8'h01, 8'd6,   2'd0, 8'h00, 1'b1, 8'hFF},  // R7 erased
    '{8'h01, 8'd8,   2'd0, 8'h00, 1'b1, 8'hA5}   // R7 neighbour page intact
  };

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk); mode_we = 1; mode_wdata = m;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    @(negedge clk); addr_we = 1; addr_wdata = AW'(a);
    @(negedge clk); addr_we = 0;
  endtask

  task automatic do_req(input logic [1:0] op, input logic [7:0] d,
                        output logic v, output logic ack, output logic [7:0] rd);
    @(negedge clk); req_valid = 1; req_op = op; req_wdata = d;
    @(negedge clk); req_valid = 0;
    v = resp_valid; ack = resp_ack; rd = resp_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic v, a;
    logic [7:0] rd;
    int n;
    rst_n = 0; mode_we = 0; addr_we = 0; req_valid = 0;
    mode_wdata = 0; addr_wdata = 0; req_op = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    check(mode_q == 8'h00, "R13 mode after reset", mode_q, 0);
    check(!busy && !hold && !resp_valid, "R13 idle outputs", {busy, hold, resp_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      set_mode(VECS[i].mode);
      set_addr(VECS[i].addr);
      do_req(VECS[i].op, VECS[i].wdata, v, a, rd);
      check(v == 1'b1, $sformatf("R12 vec%0d resp_valid", i), v, 1);
      check(a == VECS[i].ack, $sformatf("R3/R5/R6/R7 vec%0d ack", i), a, VECS[i].ack);
      if (VECS[i].op == 2'd0 && VECS[i].ack)
        check(rd == VECS[i].rdata, $sformatf("R12 vec%0d rdata", i), rd, VECS[i].rdata);
      wait_idle();
    end

    // R1 mode readback drops bits 4..6
    set_mode(8'hF7);
    check(mode_q == 8'h87, "R1 mode readback", mode_q, 8'h87);

    // R8 program busy length
    set_mode(8'h02); set_addr(8'd30);
    do_req(2'd1, 8'h12, v, a, rd);
    check(a && busy, "R8 busy rises with accept", {a, busy}, 3);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == PC, "R8 program busy cycles", n, PC);

    // R8 erase busy length
    set_mode(8'h04);
    do_req(2'd2, 8'h00, v, a, rd);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(a && n == EC, "R8 erase busy cycles", n, EC);

    // R9 request while busy without extension
    set_mode(8'h02); set_addr(8'd40);
    do_req(2'd1, 8'h77, v, a, rd);
    set_addr(8'd41);
    do_req(2'd1, 8'h66, v, a, rd);
    check(v && !a, "R9 refused while busy", {v, a}, 2);
    wait_idle();
    set_mode(8'h01);
    do_req(2'd0, 8'h00, v, a, rd);
    check(rd == 8'hFF, "R9 byte untouched", rd, 8'hFF);

    // R10 clock extension parks request
    set_mode(8'h82); set_addr(8'd50);
    do_req(2'd1, 8'h44, v, a, rd);
    set_addr(8'd51);
    do_req(2'd1, 8'h55, v, a, rd);
    check(!v && hold, "R10 parked silently", {v, hold}, 1);
    do_req(2'd0, 8'h00, v, a, rd);
    check(!v, "R10 request dropped while hold", v, 0);
    n = 0;
    while (!resp_valid && n < 200) begin n++; @(negedge clk); end
    check(resp_valid && resp_ack && !busy || resp_valid && resp_ack, "R10 parked request accepted",
          {resp_valid, resp_ack}, 3);
    wait_idle();
    set_mode(8'h01);
    do_req(2'd0, 8'h00, v, a, rd);
    check(rd == 8'h55, "R10 parked program landed", rd, 8'h55);

    // R11 address write with no mode set
    set_mode(8'h00); set_addr(8'd50);
    set_mode(8'h01);
    do_req(2'd0, 8'h00, v, a, rd);
    check(a && rd == 8'h44, "R11 address taken with no mode", rd, 8'h44);

    // R4 / R2 write protect
    set_mode(8'h0A); set_addr(8'd60);
    do_req(2'd1, 8'h01, v, a, rd);
    check(v && !a, "R4 program refused under protect", a, 0);
    set_mode(8'h02);
    check(mode_q[3] == 1'b1, "R2 protect sticky", mode_q, 8'h0A);
    do_req(2'd1, 8'h01, v, a, rd);
    check(!a, "R2 still refused", a, 0);
    set_mode(8'h04);
    do_req(2'd2, 8'h00, v, a, rd);
    check(!busy && !a, "R4 erase refused under protect", a, 0);
    set_mode(8'h01);
    do_req(2'd0, 8'h00, v, a, rd);
    check(a && rd == 8'hFF, "R4 read allowed under protect", rd, 8'hFF);

    // R13 / R2 reset clears protect and array
    do_reset();
    check(mode_q == 8'h00, "R2 protect cleared by reset", mode_q, 0);
    set_mode(8'h01); set_addr(8'd8);
    do_req(2'd0, 8'h00, v, a, rd);
    check(rd == 8'hFF, "R13 array erased by reset", rd, 8'hFF);
    set_mode(8'h02);
    do_req(2'd1, 8'h9C, v, a, rd);
    check(a, "R2 program allowed after reset", a, 1);
    wait_idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule